// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Unit

This unit sits beside a processor core and turns five hardware interrupt lines, plus software restart requests, into a single pending flag and a 16-bit service address. The lines use different sensing rules: a non-maskable trap input that needs both a rising edge and a held level, a "7.5" restart line whose rising edge is captured in a latch, two level-sensed restart lines ("6.5" and "5.5"), and a general level-sensed request that carries no address of its own. The unit picks one source by fixed priority and presents it until the core acknowledges it.

Software writes configuration through a small write-only port. Address 0 holds the per-level masks and a latch-clear strobe. Address 1 holds the global enable. The core pulses an acknowledge input to retire the request that is shown at that moment. A restart instruction in software is posted through a separate request port with a 3-bit restart number.

Every output is a function of registered state only. A change on any input appears at the outputs after exactly one rising clock edge.

Top module: `irq_vector_unit`

## Requirements
- R1: The trap source cannot be masked and is not gated by the global enable. It outranks every hardware source, and its vector is 0x0024.
- R2: A trap is accepted only after a rising edge on `trap_i`, and only while the line stays high. If the line falls, the request is withdrawn. After the trap is acknowledged with the line still high, it is not presented again until a new rising edge.
- R3: A rising edge on `rst75_i` is held in a latch with vector 0x003C. The latch survives masking. It is cleared only by an acknowledge of this source, or by a write to address 0 with bit 4 set. A new edge in the same cycle as a clear keeps the latch set.
- R4: `rst65_i` and `rst55_i` are level-sensed, with vectors 0x0034 and 0x002C.
- R5: Hardware sources rank, from highest to lowest: trap, 7.5, 6.5, 5.5, general request.
- R6: When the general request is selected, `vec_o` is 0x0000 and `ext_vec_o` is 1, which means an external device must supply the address. For every other source `ext_vec_o` is 0.
- R7: The 7.5, 6.5, 5.5 and general sources are presented only while the global enable is 1. The global enable is written through address 1, bit 0, and is visible on `ien_o`.
- R8: A write to address 0 sets the masks: bit 0 masks 5.5, bit 1 masks 6.5, bit 2 masks 7.5. A 1 blocks the source.
- R9: Acknowledging a 7.5, 6.5, 5.5 or general request clears the global enable in the same edge. If a write to address 1 lands in that edge, the clear wins. Acknowledging a trap or a software restart leaves the enable unchanged. An acknowledge with nothing pending has no effect.
- R10: A software restart request with number n (0 to 7) is held until acknowledged. It outranks all other sources, ignores masks and the enable, and returns vector n*8.
- R11: After reset nothing is pending, `ien_o` is 0 and all masks are 0.
- R12: Outputs depend only on registered state. An input change becomes visible after exactly one rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| trap_i | input | 1 | Non-maskable trap line (edge plus level) |
| rst75_i | input | 1 | Restart 7.5 line (rising edge, latched) |
| rst65_i | input | 1 | Restart 6.5 line (level) |
| rst55_i | input | 1 | Restart 5.5 line (level) |
| gen_req_i | input | 1 | General non-vectored request (level) |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 1 | Configuration address: 0 masks/clear, 1 enable |
| cfg_wdata_i | input | 8 | Configuration write data |
| sw_req_i | input | 1 | Software restart request pulse |
| sw_num_i | input | 3 | Software restart number |
| ack_i | input | 1 | Acknowledge of the presented request |
| pend_o | output | 1 | A request is presented |
| vec_o | output | 16 | Service address of the presented request |
| ext_vec_o | output | 1 | General request selected; address comes from outside |
| ien_o | output | 1 | Global enable state |

## Verification
Every result here is due one rising edge after the input, write or acknowledge that causes it. This holds for a newly sampled level, a captured 7.5 or trap edge, a mask or enable write, a software post, and an acknowledge that clears a latch or the enable. The bench drives inputs 1 ns after a rising edge, so each stimulus is taken by the next edge. A behavioural reference model advances on that same edge. At every falling edge the model's pend, vector, external flag and enable are compared with the outputs. The directed checks are read 1 ns after the edge that takes the stimulus, at the point where the one-edge latency says the result must already stand.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int VEC_W  = 16;
    localparam int NUM_W  = 3;
    localparam int CFG_W  = 8;

    // source index, also the priority order (lower index wins)
    localparam int N_SRC    = 6;
    localparam int I_SW     = 0;
    localparam int I_TRAP   = 1;
    localparam int I_R75    = 2;
    localparam int I_R65    = 3;
    localparam int I_R55    = 4;
    localparam int I_GEN    = 5;

    typedef enum logic [2:0] {
        SRC_NONE, SRC_SW, SRC_TRAP, SRC_R75, SRC_R65, SRC_R55, SRC_GEN
    } irq_src_e;

    // vector address in half-restart steps: vector = half_index * 4
    function automatic logic [VEC_W-1:0] half_vec(input logic [NUM_W+1:0] half_idx);
        half_vec = VEC_W'({half_idx, 2'b00});
    endfunction
endpackage

// File: rtl/irq_cfg.sv
module irq_cfg
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic             addr_i,
    input  logic [CFG_W-1:0] wdata_i,
    input  logic             ien_clr_i,
    output logic [2:0]       mask_o,
    output logic             ien_o,
    output logic             clr75_o
);
    typedef struct packed {
        logic [2:0] mask;
        logic       ien;
    } cfg_t;

    cfg_t d, q;

    always_comb begin
        d = q;
        if (we_i && !addr_i) d.mask = wdata_i[2:0];
        if (we_i &&  addr_i) d.ien  = wdata_i[0];
        if (ien_clr_i)       d.ien  = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mask_o  = q.mask;
    assign ien_o   = q.ien;
    assign clr75_o = we_i && !addr_i && wdata_i[4];
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_pkg::*;
(
    input  logic [N_SRC-1:0] req_i,
    input  logic [NUM_W-1:0] sw_num_i,
    output logic             pend_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             ext_o,
    output irq_src_e         src_o
);
    // half-step index of each fixed restart level
    localparam logic [NUM_W+1:0] H_TRAP = 5'd9;
    localparam logic [NUM_W+1:0] H_R75  = 5'd15;
    localparam logic [NUM_W+1:0] H_R65  = 5'd13;
    localparam logic [NUM_W+1:0] H_R55  = 5'd11;

    always_comb begin
        src_o = SRC_NONE;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) src_o = irq_src_e'(i + 1);
        end
        pend_o = (src_o != SRC_NONE);
        ext_o  = (src_o == SRC_GEN);
        case (src_o)
            SRC_SW:   vec_o = half_vec({1'b0, sw_num_i, 1'b0});
            SRC_TRAP: vec_o = half_vec(H_TRAP);
            SRC_R75:  vec_o = half_vec(H_R75);
            SRC_R65:  vec_o = half_vec(H_R65);
            SRC_R55:  vec_o = half_vec(H_R55);
            default:  vec_o = '0;
        endcase
    end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_i,
    input  logic             rst75_i,
    input  logic             rst65_i,
    input  logic             rst55_i,
    input  logic             gen_req_i,
    input  logic             cfg_we_i,
    input  logic             cfg_addr_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    input  logic             sw_req_i,
    input  logic [NUM_W-1:0] sw_num_i,
    input  logic             ack_i,
    output logic             pend_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             ext_vec_o,
    output logic             ien_o
);
    typedef struct packed {
        logic             trap_s;
        logic             trap_arm;
        logic             s75;
        logic             lat75;
        logic             s65;
        logic             s55;
        logic             sgen;
        logic             sw_v;
        logic [NUM_W-1:0] sw_n;
    } sense_t;

    sense_t d, q;

    logic [2:0]       mask;
    logic             clr75;
    logic             ien_clr;
    logic [N_SRC-1:0] req;
    irq_src_e         src;
    logic             ack_hit;
    logic             maskable_sel;

    assign ack_hit      = ack_i && pend_o;
    assign maskable_sel = (src == SRC_R75) || (src == SRC_R65) ||
                          (src == SRC_R55) || (src == SRC_GEN);
    assign ien_clr      = ack_hit && maskable_sel;

    always_comb begin
        req          = '0;
        req[I_SW]    = q.sw_v;
        req[I_TRAP]  = q.trap_arm && q.trap_s;
        req[I_R75]   = q.lat75 && !mask[2] && ien_o;
        req[I_R65]   = q.s65   && !mask[1] && ien_o;
        req[I_R55]   = q.s55   && !mask[0] && ien_o;
        req[I_GEN]   = q.sgen  && ien_o;
    end

    always_comb begin
        d          = q;
        d.trap_s   = trap_i;
        d.trap_arm = trap_i && (!q.trap_s ||
                     (q.trap_arm && !(ack_hit && src == SRC_TRAP)));
        d.s75      = rst75_i;
        d.lat75    = (rst75_i && !q.s75) ||
                     (q.lat75 && !clr75 && !(ack_hit && src == SRC_R75));
        d.s65      = rst65_i;
        d.s55      = rst55_i;
        d.sgen     = gen_req_i;
        d.sw_v     = sw_req_i || (q.sw_v && !(ack_hit && src == SRC_SW));
        if (sw_req_i) d.sw_n = sw_num_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    irq_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (cfg_we_i),
        .addr_i    (cfg_addr_i),
        .wdata_i   (cfg_wdata_i),
        .ien_clr_i (ien_clr),
        .mask_o    (mask),
        .ien_o     (ien_o),
        .clr75_o   (clr75)
    );

    irq_pick u_pick (
        .req_i    (req),
        .sw_num_i (q.sw_n),
        .pend_o   (pend_o),
        .vec_o    (vec_o),
        .ext_o    (ext_vec_o),
        .src_o    (src)
    );

    // R9
    ien_ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && pend_o && maskable_sel) |=> !ien_o);

    // R1
    trap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.trap_arm && !q.sw_v) |-> (pend_o && vec_o == 16'h0024));

    // R3
    lat75_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lat75 && !clr75 && !(ack_hit && src == SRC_R75)) |=> q.lat75);

    // R7
    ien_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_o |-> !(pend_o && maskable_sel));

    // R6
    ext_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_vec_o |-> (pend_o && vec_o == '0));
endmodule

// File: tb/irq_vector_unit_tb.sv
module irq_vector_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_i = 0, rst75_i = 0, rst65_i = 0, rst55_i = 0, gen_req_i = 0;
    logic        cfg_we_i = 0, cfg_addr_i = 0;
    logic [7:0]  cfg_wdata_i = '0;
    logic        sw_req_i = 0;
    logic [2:0]  sw_num_i = '0;
    logic        ack_i = 0;
    logic        pend_o, ext_vec_o, ien_o;
    logic [15:0] vec_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_vector_unit u_dut (
        .clk(clk), .rst_n(rst_n), .trap_i(trap_i), .rst75_i(rst75_i),
        .rst65_i(rst65_i), .rst55_i(rst55_i), .gen_req_i(gen_req_i),
        .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
        .sw_req_i(sw_req_i), .sw_num_i(sw_num_i), .ack_i(ack_i),
        .pend_o(pend_o), .vec_o(vec_o), .ext_vec_o(ext_vec_o), .ien_o(ien_o)
    );

    // ---------------- reference model ----------------
    // source codes: 0 none, 1 sw, 2 trap, 3 r75, 4 r65, 5 r55, 6 gen
    bit       m_trap_s, m_arm, m_s75, m_lat75, m_s65, m_s55, m_gen, m_ien, m_swv;
    bit [2:0] m_mask;
    int       m_swn;

    function automatic int m_src();
        if (m_swv) return 1;
        if (m_arm && m_trap_s) return 2;
        if (m_ien && m_lat75 && !m_mask[2]) return 3;
        if (m_ien && m_s65 && !m_mask[1]) return 4;
        if (m_ien && m_s55 && !m_mask[0]) return 5;
        if (m_ien && m_gen) return 6;
        return 0;
    endfunction

    function automatic int m_vec(input int s);
        case (s)
            1: return m_swn * 8;
            2: return 36;
            3: return 60;
            4: return 52;
            5: return 44;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input int s);
        case (s)
            1: return "R10";
            2: return "R1";
            3: return "R3";
            4, 5: return "R4";
            6: return "R6";
            default: return "R7";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_trap_s = 0; m_arm = 0; m_s75 = 0; m_lat75 = 0; m_s65 = 0;
            m_s55 = 0; m_gen = 0; m_ien = 0; m_swv = 0; m_mask = '0; m_swn = 0;
        end else begin
            int  s;
            bit  ackd, clr, n_arm, n_lat, n_ien;
            s    = m_src();
            ackd = ack_i && (s != 0);
            clr  = cfg_we_i && !cfg_addr_i && cfg_wdata_i[4];
            n_arm = trap_i && (!m_trap_s || (m_arm && !(ackd && s == 2)));
            n_lat = (rst75_i && !m_s75) || (m_lat75 && !clr && !(ackd && s == 3));
            n_ien = m_ien;
            if (cfg_we_i && cfg_addr_i) n_ien = cfg_wdata_i[0];
            if (ackd && s >= 3) n_ien = 0;
            if (cfg_we_i && !cfg_addr_i) m_mask = cfg_wdata_i[2:0];
            if (ackd && s == 1) m_swv = 0;
            if (sw_req_i) begin m_swv = 1; m_swn = sw_num_i; end
            m_arm = n_arm; m_lat75 = n_lat; m_ien = n_ien;
            m_trap_s = trap_i; m_s75 = rst75_i; m_s65 = rst65_i;
            m_s55 = rst55_i; m_gen = gen_req_i;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int s;
            s = m_src();
            chk(tag_of(s), int'(pend_o), int'(s != 0));
            chk(tag_of(s), int'(vec_o), m_vec(s));
            chk("R6", int'(ext_vec_o), int'(s == 6));
            chk("R9", int'(ien_o), int'(m_ien));
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic wr(input bit a, input logic [7:0] v);
        cfg_we_i = 1; cfg_addr_i = a; cfg_wdata_i = v;
        cyc();
        cfg_we_i = 0;
    endtask

    task automatic ack();
        ack_i = 1; cyc(); ack_i = 0;
    endtask

    task automatic post_sw(input logic [2:0] n);
        sw_req_i = 1; sw_num_i = n; cyc(); sw_req_i = 0;
    endtask

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        chk("R11", int'(pend_o), 0);
        chk("R11", int'(ien_o), 0);

        wr(1, 8'h01);
        chk("R7", int'(ien_o), 1);
        rst55_i = 1; cyc();
        chk("R12", int'(pend_o), 1);
        chk("R4", int'(vec_o), 16'h002C);
        rst65_i = 1; cyc();
        chk("R5", int'(vec_o), 16'h0034);
        wr(0, 8'h02);
        chk("R8", int'(vec_o), 16'h002C);
        wr(1, 8'h00);
        chk("R7", int'(pend_o), 0);
        rst55_i = 0; rst65_i = 0;

        wr(0, 8'h04);
        rst75_i = 1; cyc(); rst75_i = 0; cyc();
        wr(1, 8'h01);
        chk("R3", int'(pend_o), 0);
        wr(0, 8'h00);
        chk("R3", int'(vec_o), 16'h003C);
        ack();
        chk("R9", int'(ien_o), 0);
        wr(1, 8'h01);
        chk("R3", int'(pend_o), 0);
        rst75_i = 1; cyc(); rst75_i = 0;
        chk("R3", int'(vec_o), 16'h003C);
        wr(0, 8'h10);
        chk("R3", int'(pend_o), 0);

        rst55_i = 1; gen_req_i = 1;
        trap_i = 1; cyc();
        chk("R1", int'(vec_o), 16'h0024);
        ack();
        chk("R9", int'(ien_o), 1);
        chk("R2", int'(vec_o), 16'h002C);
        trap_i = 0; cyc();
        trap_i = 1; cyc();
        chk("R2", int'(vec_o), 16'h0024);
        trap_i = 0; cyc();
        chk("R2", int'(vec_o), 16'h002C);

        ack();
        rst55_i = 0;
        wr(1, 8'h01);
        chk("R6", int'(ext_vec_o), 1);
        chk("R6", int'(vec_o), 0);
        rst55_i = 1; cyc();
        chk("R5", int'(vec_o), 16'h002C);
        rst55_i = 0; gen_req_i = 0;
        wr(1, 8'h00);

        post_sw(3'd5);
        chk("R10", int'(vec_o), 16'h0028);
        trap_i = 1; cyc();
        chk("R10", int'(vec_o), 16'h0028);
        ack();
        chk("R1", int'(vec_o), 16'h0024);
        ack();
        trap_i = 0;
        post_sw(3'd7);
        chk("R10", int'(vec_o), 16'h0038);
        ack();
        post_sw(3'd0);
        chk("R10", int'(pend_o), 1);
        chk("R10", int'(vec_o), 0);
        ack();
        cyc();

        for (int i = 0; i < 400; i++) begin
            trap_i    = ($urandom_range(0, 7) == 0) ? ~trap_i : trap_i;
            rst75_i   = $urandom_range(0, 1);
            rst65_i   = ($urandom_range(0, 3) == 0);
            rst55_i   = ($urandom_range(0, 3) == 0);
            gen_req_i = ($urandom_range(0, 3) == 0);
            ack_i     = ($urandom_range(0, 2) == 0);
            sw_req_i  = ($urandom_range(0, 15) == 0);
            sw_num_i  = 3'($urandom_range(0, 7));
            cfg_we_i  = ($urandom_range(0, 4) == 0);
            cfg_addr_i = $urandom_range(0, 1);
            cfg_wdata_i = 8'($urandom_range(0, 255));
            cyc();
        end
        ack_i = 0; cfg_we_i = 0; sw_req_i = 0;
        cyc();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule